// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address front end of a synchronous burst memory. On a rising clock edge it takes in a full word address, together with three chip-enable qualifiers, when either of its two active-low address strobes is asserted. One strobe serves a processor and is gated by the first chip enable. The other serves a cache or bus controller and always loads. After a load, the lowest two address bits step through a four-beat burst each time the active-low advance input is held low. The upper bits stay as they were captured.

A live order-select input picks the burst order. Linear order adds the beat count to the start offset, modulo four. Interleaved order XORs the beat count into the start offset. The output is the current word address plus a registered flag that tells the memory array whether the access is selected. The address reaches the array without an output register. A change on the order select therefore shows on the address in the same cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset clears the selected flag, the beat count and the captured address, so `sel_out` is 0 and `word_addr` is 0 after the reset edge.
- R2: With `strobe_proc_n` low and `ce1_n` low at a rising edge, `addr_in` is captured. `sel_out` becomes 1 only if `ce2` is 1 and `ce3_n` is 0.
- R3: With `strobe_proc_n` low, `ce1_n` high and `strobe_ctrl_n` high, the edge has no effect. The address and `sel_out` keep their previous values.
- R4: With `strobe_ctrl_n` low at a rising edge, `addr_in` is captured whatever the value of `ce1_n`. `sel_out` becomes `!ce1_n & ce2 & !ce3_n`.
- R5: With both strobes low, the processor strobe takes the load when `ce1_n` is low. When `ce1_n` is high, the controller strobe loads and the result is deselected.
- R6: With no strobe low, `advance_n` low and `sel_out` 1, the beat count steps by one. For `order_sel` = 0 (linear), the low two address bits are (start + beat) mod 4.
- R7: For `order_sel` = 1 (interleaved), the low two address bits are start XOR beat.
- R8: With no strobe low and either `advance_n` high or `sel_out` 0, the edge leaves the address unchanged.
- R9: The burst wraps after four beats. The fourth advance brings the low two bits back to their start value with no carry into bits above bit 1, and those upper bits keep their captured value throughout.
- R10: `order_sel` acts on `word_addr` combinationally, in the same cycle, and does not change the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External word address |
| strobe_proc_n | input | 1 | Processor address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | First chip enable, active low |
| ce2 | input | 1 | Second chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| word_addr | output | ADDR_W | Current word address to the array |
| sel_out | output | 1 | Registered selected flag |

## Verification
A beat count that is off by one or stuck shows on the low two bits of `word_addr` at the first edge after the bad step. No cycle hides it, because the address has no output register. A misjudged strobe priority or enable gate appears one edge after the strobe, either as a wrong `sel_out` or as an address that moved when it should have held. A carry that leaks out of the counter changes the upper bits at the fourth advance of a burst, which the wrap sweep from every start offset exposes.

// File: rtl/bas_pkg.sv
package bas_pkg;
  // Burst order selected by the order_sel pin.
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bas_strobe_arb.sv
module bas_strobe_arb (
  input  logic clk,
  input  logic rst,
  input  logic strobe_proc_n,
  input  logic strobe_ctrl_n,
  input  logic ce1_n,
  input  logic ce2,
  input  logic ce3_n,
  output logic proc_take,
  output logic ctrl_take,
  output logic load,
  output logic sel_next
);
  logic enables_ok;

  assign enables_ok = !ce1_n && ce2 && !ce3_n;
  // The processor strobe only counts while the first enable is active.
  assign proc_take  = !strobe_proc_n && !ce1_n;
  // The controller strobe loads unless the processor strobe already did.
  assign ctrl_take  = !strobe_ctrl_n && !proc_take;
  assign load       = proc_take || ctrl_take;
  assign sel_next   = enables_ok;

  // R5: never two load sources in one cycle
  p_one_source_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({proc_take, ctrl_take}));

  // R4: a controller strobe always produces a load
  p_ctrl_loads_r4: assert property (@(posedge clk) disable iff (rst)
    !strobe_ctrl_n |-> load);
endmodule

// File: rtl/bas_beat_counter.sv
module bas_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] count
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= '0;
    else if (step) count <= count + ONE;
  end

  // R6: an advance moves the count by exactly one, wrapping naturally
  p_step_one_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> count == $past(count) + ONE);

  // R8: no load and no step leaves the count alone
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(count));

  // R9: every burst starts from beat zero
  p_load_zero_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> count == '0);
endmodule

// File: rtl/bas_addr_map.sv
module bas_addr_map
  import bas_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] count,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] low_bits
);
  function automatic logic [BEAT_W-1:0] linear_beat(
    input logic [BEAT_W-1:0] s, input logic [BEAT_W-1:0] k);
    return s + k;
  endfunction

  function automatic logic [BEAT_W-1:0] xor_beat(
    input logic [BEAT_W-1:0] s, input logic [BEAT_W-1:0] k);
    return s ^ k;
  endfunction

  logic [BEAT_W-1:0] lin_bits;
  logic [BEAT_W-1:0] xor_bits;

  assign lin_bits = linear_beat(start, count);
  assign xor_bits = xor_beat(start, count);
  assign low_bits = (order == ORD_XOR) ? xor_bits : lin_bits;

  // R10: both orders agree on beat zero
  always_comb begin
    if (count == '0) begin
      a_beat0_r10: assert (lin_bits == xor_bits);
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_proc_n,
  input  logic              strobe_ctrl_n,
  input  logic              advance_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] word_addr,
  output logic              sel_out
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_addr;
  logic [BEAT_W-1:0] count;
  logic [BEAT_W-1:0] low_bits;
  logic              proc_take;
  logic              ctrl_take;
  logic              load;
  logic              sel_next;
  logic              step;

  bas_strobe_arb u_arb (
    .clk           (clk),
    .rst           (rst),
    .strobe_proc_n (strobe_proc_n),
    .strobe_ctrl_n (strobe_ctrl_n),
    .ce1_n         (ce1_n),
    .ce2           (ce2),
    .ce3_n         (ce3_n),
    .proc_take     (proc_take),
    .ctrl_take     (ctrl_take),
    .load          (load),
    .sel_next      (sel_next)
  );

  // Advance counts only within a selected burst.
  assign step = !load && !advance_n && sel_out;

  bas_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .step  (step),
    .count (count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      sel_out   <= 1'b0;
    end else if (load) begin
      base_addr <= addr_in;
      sel_out   <= sel_next;
    end
  end

  bas_addr_map #(.BEAT_W(BEAT_W)) u_map (
    .start    (base_addr[BEAT_W-1:0]),
    .count    (count),
    .order    (burst_order_e'(order_sel)),
    .low_bits (low_bits)
  );

  assign word_addr = {base_addr[ADDR_W-1:BEAT_W], low_bits};

  // R9: upper bits never move between loads
  p_upper_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(word_addr[ADDR_W-1:ADDR_W-HI_W]));

  // R4: an unqualified load deselects
  p_deselect_r4: assert property (@(posedge clk) disable iff (rst)
    (load && !sel_next) |=> !sel_out);

  // R3: gated processor strobe alone changes nothing
  p_proc_gated_r3: assert property (@(posedge clk) disable iff (rst)
    (!strobe_proc_n && ce1_n && strobe_ctrl_n) |=> $stable(sel_out));

  // R2: a processor load captures the address
  p_proc_capture_r2: assert property (@(posedge clk) disable iff (rst)
    proc_take |=> word_addr[ADDR_W-1:BEAT_W] == $past(addr_in[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              strobe_proc_n = 1'b1;
  logic              strobe_ctrl_n = 1'b1;
  logic              advance_n = 1'b1;
  logic              ce1_n = 1'b0;
  logic              ce2 = 1'b1;
  logic              ce3_n = 1'b0;
  logic              order_sel = 1'b0;
  logic [ADDR_W-1:0] word_addr;
  logic              sel_out;

  int n_checks = 0;
  int n_fail = 0;

  // Reference order: row = start offset, column = beat.
  localparam logic [1:0] LIN_T [4][4] = '{
    '{2'd0, 2'd1, 2'd2, 2'd3}, '{2'd1, 2'd2, 2'd3, 2'd0},
    '{2'd2, 2'd3, 2'd0, 2'd1}, '{2'd3, 2'd0, 2'd1, 2'd2}};
  localparam logic [1:0] XOR_T [4][4] = '{
    '{2'd0, 2'd1, 2'd2, 2'd3}, '{2'd1, 2'd0, 2'd3, 2'd2},
    '{2'd2, 2'd3, 2'd0, 2'd1}, '{2'd3, 2'd2, 2'd1, 2'd0}};

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .addr_in(addr_in),
    .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
    .advance_n(advance_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .order_sel(order_sel), .word_addr(word_addr), .sel_out(sel_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b1; advance_n = 1'b1;
  endtask

  task automatic load_proc(input logic [ADDR_W-1:0] a, input logic c1n,
                           input logic c2, input logic c3n);
    addr_in = a; ce1_n = c1n; ce2 = c2; ce3_n = c3n;
    strobe_proc_n = 1'b0; strobe_ctrl_n = 1'b1; advance_n = 1'b1;
    tick();
    idle();
  endtask

  task automatic load_ctrl(input logic [ADDR_W-1:0] a, input logic c1n,
                           input logic c2, input logic c3n);
    addr_in = a; ce1_n = c1n; ce2 = c2; ce3_n = c3n;
    strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b0; advance_n = 1'b1;
    tick();
    idle();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    chk("R1 sel_out after reset", 32'(sel_out), 32'd0);
    chk("R1 word_addr after reset", 32'(word_addr), 32'd0);
  endtask

  task automatic t_proc_load();
    load_proc(20'hA5F31, 1'b0, 1'b1, 1'b0);
    chk("R2 proc capture addr", 32'(word_addr), 32'h A5F31);
    chk("R2 proc qualified sel", 32'(sel_out), 32'd1);
    load_proc(20'h0C3E6, 1'b0, 1'b0, 1'b0);
    chk("R2 proc capture with ce2 low", 32'(word_addr), 32'h0C3E6);
    chk("R2 proc ce2 low deselects", 32'(sel_out), 32'd0);
  endtask

  task automatic t_proc_gated();
    load_proc(20'h12344, 1'b0, 1'b1, 1'b0);
    load_proc(20'hFEDC9, 1'b1, 1'b1, 1'b0);
    chk("R3 gated proc keeps addr", 32'(word_addr), 32'h12344);
    chk("R3 gated proc keeps sel", 32'(sel_out), 32'd1);
  endtask

  task automatic t_ctrl_load();
    load_ctrl(20'h77772, 1'b1, 1'b1, 1'b0);
    chk("R4 ctrl capture with ce1 off", 32'(word_addr), 32'h77772);
    chk("R4 ctrl ce1 off deselects", 32'(sel_out), 32'd0);
    load_ctrl(20'h3BAD1, 1'b0, 1'b1, 1'b0);
    chk("R4 ctrl qualified addr", 32'(word_addr), 32'h3BAD1);
    chk("R4 ctrl qualified sel", 32'(sel_out), 32'd1);
    load_ctrl(20'h55550, 1'b0, 1'b1, 1'b1);
    chk("R4 ctrl ce3 off deselects", 32'(sel_out), 32'd0);
  endtask

  task automatic t_both();
    addr_in = 20'h9ABC2; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    strobe_proc_n = 1'b0; strobe_ctrl_n = 1'b0;
    tick(); idle();
    chk("R5 both strobes ce1 on addr", 32'(word_addr), 32'h9ABC2);
    chk("R5 both strobes ce1 on sel", 32'(sel_out), 32'd1);
    addr_in = 20'h41003; ce1_n = 1'b1;
    strobe_proc_n = 1'b0; strobe_ctrl_n = 1'b0;
    tick(); idle();
    chk("R5 both strobes ce1 off addr", 32'(word_addr), 32'h41003);
    chk("R5 both strobes ce1 off sel", 32'(sel_out), 32'd0);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [17:0] hi;
        logic [1:0]  e;
        hi = 18'h2A5C3 ^ 18'(m * 4 + s);
        order_sel = m[0];
        load_ctrl({hi, s[1:0]}, 1'b0, 1'b1, 1'b0);
        chk(m ? "R7 interleaved beat0" : "R6 linear beat0",
            32'(word_addr), 32'({hi, s[1:0]}));
        for (int k = 1; k <= 4; k++) begin
          advance_n = 1'b0;
          tick();
          e = m ? XOR_T[s][k % 4] : LIN_T[s][k % 4];
          if (k == 4)
            chk("R9 wrap to start, upper bits kept", 32'(word_addr), 32'({hi, s[1:0]}));
          else
            chk(m ? "R7 interleaved beat" : "R6 linear beat",
                32'(word_addr), 32'({hi, e}));
        end
        advance_n = 1'b1;
      end
    end
    order_sel = 1'b0;
  endtask

  task automatic t_hold();
    load_ctrl(20'h60001, 1'b0, 1'b1, 1'b0);
    advance_n = 1'b0; tick();
    advance_n = 1'b1; tick(); tick();
    chk("R8 advance high holds", 32'(word_addr), 32'h60002);
    load_ctrl(20'h60001, 1'b0, 1'b0, 1'b0);
    advance_n = 1'b0; tick(); tick();
    advance_n = 1'b1;
    chk("R8 deselected ignores advance", 32'(word_addr), 32'h60001);
  endtask

  task automatic t_order_live();
    order_sel = 1'b0;
    load_ctrl(20'h0F0F1, 1'b0, 1'b1, 1'b0);
    advance_n = 1'b0; tick(); advance_n = 1'b1;
    chk("R10 linear start1 beat1", 32'(word_addr), 32'h0F0F2);
    order_sel = 1'b1;
    #1;
    chk("R10 flip to interleaved same cycle", 32'(word_addr), 32'h0F0F0);
    advance_n = 1'b0; tick(); advance_n = 1'b1;
    chk("R10 count kept across flip", 32'(word_addr), 32'h0F0F3);
    order_sel = 1'b0;
  endtask

  initial begin
    #1;
    t_reset();
    t_proc_load();
    t_proc_gated();
    t_ctrl_load();
    t_both();
    t_sweep();
    t_hold();
    t_order_live();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule